// File: doc/BRIEF.md
# Programmable-Priority Interrupt Mask and Selector

This block gathers five level-sensitive interrupt sources and decides which one is forwarded to the processor core. The sources are a real-time-clock alarm, a message unit, a system bus agent, a DMA engine and an external IRQ4 line.

Every request is captured in a pending register, whatever its enable bit says. An enable mask then decides which pending sources may compete. The competing sources are ranked by a software-written priority table of eight slots. Each slot holds a 3-bit code naming the source that sits at that rank. Software can rewrite the table, the mask and the pending bits at any time through a small register port. The block drives a single request to the core together with the 3-bit code of the winning source.

The register port has three words. Address 0 is the priority table, address 1 is the enable mask and address 2 is the pending register; address 3 reads as zero. Reads are combinational. Writes take effect at the clock edge on which the write enable is sampled high.

Top module: `prio_irq_select`

## Requirements
- R1: After reset the enable mask reads 0, the pending register reads 0, the priority word reads 0x05309FF0 (slot n holds code n for n = 0 to 4, and slots 5 to 7 hold 111), and `irq_req` is low.
- R2: In the priority word, slot s for s = 0 to 3 sits in bits [31-3s : 29-3s], and slot s for s = 4 to 7 sits in bits [15-3(s-4) : 13-3(s-4)]. Bits [19:16] and [3:0] ignore writes and read as zero.
- R3: Slot codes 0 to 4 name source bit 0 (real-time-clock alarm), 1 (message unit), 2 (system bus agent), 3 (DMA) and 4 (IRQ4). Codes 5, 6 and 7 name no source, so a slot holding one of them never produces a request.
- R4: A source that is high at a clock edge sets its pending bit (bit index equal to its code), and this happens even while its enable bit is 0.
- R5: An enable bit of 0 keeps that source from being forwarded. When software clears the enable bit of the current winner, the request is withdrawn, or passed to the next candidate, from the cycle after the write.
- R6: A source that is still pending when its enable bit is set to 1 is forwarded from the cycle after that write.
- R7: `irq_req` is high when at least one slot names a source that is both pending and enabled. `irq_id` is then the code held in the lowest-numbered such slot, and slot 0 has the highest rank.
- R8: A rewrite of the priority word changes the ranking from the cycle after the write, with no reset.
- R9: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If the source is high in the same cycle as the clearing write, the bit stays set.
- R10: The enable mask reads back the last value written in bits [4:0], and bits [31:5] read as zero.
- R11: The same code may sit in more than one slot. That source is then ranked by its best slot, and nothing else changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_i | input | 5 | Level requests, bit index equals the source code |
| reg_addr | input | 2 | Register select: 0 priority, 1 mask, 2 pending |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| irq_req | output | 1 | Request forwarded to the core |
| irq_id | output | 3 | Code of the winning source, valid while `irq_req` is high |

## Verification
On every cycle, the assertions check the following: a forwarded request always names a real source code that is pending and enabled; an active source always shows up in its pending bit on the next cycle; a clearing write empties every bit whose source was idle; and the unused bits of the priority word stay zero. Some behaviour only the directed scenarios can show, because the expected result depends on a sequence of register writes. This covers the exact ranking after a table rewrite, the hand-over to the next candidate when the winner's enable bit is dropped, reserved and duplicated codes, and set-over-clear precedence.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int NSRC   = 5;
  localparam int NSLOT  = 8;
  localparam int CODE_W = 3;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_PRIO = 2'd0,
    RA_MASK = 2'd1,
    RA_PEND = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  // Low bit of slot s in the priority word: four slots per half-word,
  // highest slot rank at the most significant end.
  function automatic int slot_lsb(input int s);
    return (REG_W - CODE_W) - (s / 4) * (REG_W / 2) - (s % 4) * CODE_W;
  endfunction
endpackage

// File: rtl/irq_prio_table.sv
module irq_prio_table
  import irq_sel_pkg::*;
#(
  parameter int N_SLOT = NSLOT,
  parameter int N_SRC  = NSRC,
  parameter int CW     = CODE_W,
  parameter int RW     = REG_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [RW-1:0]              wdata,
  output logic [N_SLOT-1:0][CW-1:0]  slot_code,
  output logic [RW-1:0]              rd_word
);
  logic [N_SLOT-1:0][CW-1:0] code_q, code_d, code_rst;

  for (genvar s = 0; s < N_SLOT; s++) begin : g_rst
    if (s < N_SRC) begin : g_real
      assign code_rst[s] = CW'(s);
    end else begin : g_resv
      assign code_rst[s] = '1;
    end
  end

  always_comb begin
    code_d = code_q;
    if (we) begin
      for (int s = 0; s < N_SLOT; s++) code_d[s] = wdata[slot_lsb(s) +: CW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= code_rst;
    else        code_q <= code_d;
  end

  always_comb begin
    rd_word = '0;
    for (int s = 0; s < N_SLOT; s++) rd_word[slot_lsb(s) +: CW] = code_q[s];
  end

  assign slot_code = code_q;

  // R2: unused field bits of the priority word never carry data
  a_r2_gap_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word[19:16] == 4'b0) && (rd_word[3:0] == 4'b0));
endmodule

// File: rtl/irq_pend_mask.sv
module irq_pend_mask
  import irq_sel_pkg::*;
#(
  parameter int N_SRC = NSRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             mask_we,
  input  logic             pend_we,
  input  logic [N_SRC-1:0] wbits,
  output logic [N_SRC-1:0] pend_q,
  output logic [N_SRC-1:0] mask_q
);
  logic [N_SRC-1:0] pend_d, mask_d, clr_bits;

  assign clr_bits = pend_we ? wbits : '0;

  always_comb begin
    pend_d = (pend_q & ~clr_bits) | src_i;   // set wins over clear
    mask_d = mask_q;
    if (mask_we) mask_d = wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
    end
  end

  // R4: an active source is recorded regardless of its enable bit
  a_r4_pend_captures: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i != '0) |=> ((pend_q & $past(src_i)) == $past(src_i)));

  // R9: clearing write empties every bit whose source was idle
  a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pend_we |=> ((pend_q & $past(wbits & ~src_i)) == '0));
endmodule

// File: rtl/irq_slot_pick.sv
module irq_slot_pick
  import irq_sel_pkg::*;
#(
  parameter int N_SLOT = NSLOT,
  parameter int N_SRC  = NSRC,
  parameter int CW     = CODE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_SLOT-1:0][CW-1:0]  slot_code,
  input  logic [N_SRC-1:0]           active,
  output logic                       req,
  output logic [CW-1:0]              id
);
  localparam int          CODES  = 1 << CW;
  localparam logic [CW-1:0] SRC_LIM = CW'(N_SRC);

  logic [CODES-1:0]  act_ext;
  logic [N_SLOT-1:0] hit;

  assign act_ext = CODES'(active);

  for (genvar s = 0; s < N_SLOT; s++) begin : g_hit
    assign hit[s] = (slot_code[s] < SRC_LIM) && act_ext[slot_code[s]];
  end

  always_comb begin
    req = 1'b0;
    id  = '0;
    for (int s = N_SLOT - 1; s >= 0; s--) begin
      if (hit[s]) begin
        req = 1'b1;
        id  = slot_code[s];
      end
    end
  end

  // R3: a reserved code never wins
  a_r3_id_is_real: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (id < SRC_LIM));
endmodule

// File: rtl/prio_irq_select.sv
module prio_irq_select
  import irq_sel_pkg::*;
#(
  parameter int N_SRC  = NSRC,
  parameter int N_SLOT = NSLOT,
  parameter int CW     = CODE_W,
  parameter int RW     = REG_W,
  parameter int AW     = ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_we,
  input  logic [RW-1:0]    reg_wdata,
  output logic [RW-1:0]    reg_rdata,
  output logic             irq_req,
  output logic [CW-1:0]    irq_id
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic                      prio_we, mask_we, pend_we;
  logic [N_SLOT-1:0][CW-1:0] slot_code;
  logic [RW-1:0]             prio_word;
  logic [N_SRC-1:0]          pend_q, mask_q;

  assign prio_we = reg_we && (reg_addr == RA_PRIO);
  assign mask_we = reg_we && (reg_addr == RA_MASK);
  assign pend_we = reg_we && (reg_addr == RA_PEND);

  irq_prio_table #(.N_SLOT(N_SLOT), .N_SRC(N_SRC), .CW(CW), .RW(RW)) u_table (
    .clk(clk), .rst_n(rst_n_s), .we(prio_we), .wdata(reg_wdata),
    .slot_code(slot_code), .rd_word(prio_word)
  );

  irq_pend_mask #(.N_SRC(N_SRC)) u_pm (
    .clk(clk), .rst_n(rst_n_s), .src_i(src_i), .mask_we(mask_we),
    .pend_we(pend_we), .wbits(reg_wdata[N_SRC-1:0]),
    .pend_q(pend_q), .mask_q(mask_q)
  );

  irq_slot_pick #(.N_SLOT(N_SLOT), .N_SRC(N_SRC), .CW(CW)) u_pick (
    .clk(clk), .rst_n(rst_n_s), .slot_code(slot_code),
    .active(pend_q & mask_q), .req(irq_req), .id(irq_id)
  );

  always_comb begin
    unique case (reg_addr)
      RA_PRIO: reg_rdata = prio_word;
      RA_MASK: reg_rdata = RW'(mask_q);
      RA_PEND: reg_rdata = RW'(pend_q);
      default: reg_rdata = '0;
    endcase
  end

  localparam int CODES = 1 << CW;
  logic [CODES-1:0] pend_ext, mask_ext;
  assign pend_ext = CODES'(pend_q);
  assign mask_ext = CODES'(mask_q);

  // R5 / R7: the forwarded source is pending and enabled
  a_r5_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_req |-> (mask_ext[irq_id] && pend_ext[irq_id]));

  // R10: unused mask bits read as zero
  a_r10_mask_upper_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_addr == RA_MASK) |-> (reg_rdata[RW-1:N_SRC] == '0));
endmodule

// File: tb/prio_irq_select_bench.sv
module prio_irq_select_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  src_i;
  logic [1:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_req;
  logic [2:0]  irq_id;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  prio_irq_select u_prio_irq_select (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_id(irq_id)
  );

  function automatic logic [31:0] pword(input logic [7:0][2:0] c);
    logic [31:0] v = '0;
    for (int s = 0; s < 4; s++) v[31 - 3*s -: 3] = c[s];
    for (int s = 4; s < 8; s++) v[15 - 3*(s-4) -: 3] = c[s];
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [4:0] v);
    @(negedge clk); src_i = v;
    @(negedge clk); src_i = '0;
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); chk("R1 prio reset", d, 32'h0530_9FF0);
    rd(2'd1, d); chk("R1 mask reset", d, 32'h0);
    rd(2'd2, d); chk("R1 pend reset", d, 32'h0);
    chk("R1 req reset", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R2 gap bits zero", d, 32'hFFF0_FFF0);
    wr(2'd0, pword({3'd7,3'd7,3'd7,3'd4,3'd3,3'd2,3'd1,3'd0}));
    rd(2'd0, d); chk("R2 slot layout", d, 32'h0530_9FF0);
  endtask

  task automatic t_masked_pend();
    logic [31:0] d;
    pulse(5'b00001);
    rd(2'd2, d); chk("R4 pend while masked", d, 32'h1);
    chk("R5 masked no req", {31'b0, irq_req}, 32'h0);
    wr(2'd1, 32'h1);
    chk("R6 unmask forwards req", {31'b0, irq_req}, 32'h1);
    chk("R6 unmask id", {29'b0, irq_id}, 32'h0);
  endtask

  task automatic t_mask_drop();
    logic [31:0] d;
    pulse(5'b11111);
    wr(2'd1, 32'h1F);
    chk("R7 slot0 wins", {28'b0, irq_req, irq_id}, 32'h8);
    wr(2'd1, 32'h1E);
    chk("R5 next candidate", {28'b0, irq_req, irq_id}, 32'h9);
    wr(2'd1, 32'h0);
    chk("R5 all masked", {31'b0, irq_req}, 32'h0);
    rd(2'd2, d); chk("R4 pend kept", d, 32'h1F);
  endtask

  task automatic t_order();
    wr(2'd1, 32'h1F);
    wr(2'd0, pword({3'd7,3'd7,3'd7,3'd0,3'd1,3'd2,3'd3,3'd4}));
    chk("R8 rewrite ranks irq4", {28'b0, irq_req, irq_id}, 32'hC);
    wr(2'd0, pword({3'd7,3'd7,3'd7,3'd7,3'd7,3'd7,3'd7,3'd7}));
    chk("R3 all reserved", {31'b0, irq_req}, 32'h0);
    wr(2'd0, pword({3'd7,3'd7,3'd7,3'd7,3'd2,3'd7,3'd6,3'd5}));
    chk("R3 reserved skipped", {28'b0, irq_req, irq_id}, 32'hA);
  endtask

  task automatic t_dup();
    logic [31:0] d;
    wr(2'd0, pword({3'd7,3'd7,3'd7,3'd7,3'd7,3'd7,3'd2,3'd2}));
    chk("R11 dup wins", {28'b0, irq_req, irq_id}, 32'hA);
    wr(2'd2, 32'h4);
    rd(2'd2, d); chk("R9 w1c single", d, 32'h1B);
    chk("R11 dup cleared no req", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(2'd2, 32'h1F);
    rd(2'd2, d); chk("R9 w1c all", d, 32'h0);
    @(negedge clk); src_i = 5'b00001;
    wr(2'd2, 32'h1);
    src_i = '0;
    rd(2'd2, d); chk("R9 set beats clear", d, 32'h1);
    wr(2'd2, 32'h0);
    rd(2'd2, d); chk("R9 zero write no effect", d, 32'h1);
  endtask

  task automatic t_mask_rb();
    logic [31:0] d;
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R10 mask readback", d, 32'h1F);
    wr(2'd1, 32'h0000_0012);
    rd(2'd1, d); chk("R10 mask value", d, 32'h12);
    rd(2'd3, d); chk("R10 unused addr zero", d, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; src_i = '0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_layout();
    t_masked_pend();
    t_mask_drop();
    t_order();
    t_dup();
    t_w1c();
    t_mask_rb();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule